// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment-relative memory reference into a flat physical address. The caller presents the current values of four segment registers, a code that says what kind of memory reference is being made, an optional segment override request, and a 16-bit offset. The block picks the segment that applies to that kind of reference. It multiplies the segment value by sixteen, adds the zero-extended offset and keeps the low 20 bits.

Every kind of reference has a default segment. Only general data and string-source references may be redirected to another segment. An override requested for any other kind is refused: the block flags it and still uses the default segment. The result, the identity of the segment actually used and the refusal flag are registered one stage behind a valid strobe. They hold their values between strobes.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `out_valid`=0, `phys_addr`=0, `seg_used`=0 and `ovr_bad`=0.
- R2: The address is `phys_addr` = (segment value × 16 + offset) taken modulo 2^20. For example, 1234h:0022h gives 12362h and 2500h:95F3h gives 2E5F3h.
- R3: A sum above FFFFFh wraps, so the carry out of bit 19 is lost. For example, FFFFh:0010h gives 00000h and FFFFh:FFFFh gives 0FFEFh.
- R4: Reference kind 0 is an instruction fetch. It always uses the code segment, reported as `seg_used`=1.
- R5: Reference kind 1 is a stack reference. It always uses the stack segment, reported as `seg_used`=2.
- R6: Reference kind 4 is a string destination. It always uses the extra segment, reported as `seg_used`=0.
- R7: Reference kinds 2 (general data) and 3 (string source) use the data segment (`seg_used`=3) when `ovr_en`=0. When `ovr_en`=1 they use the segment named by `ovr_seg`, with 0=extra, 1=code, 2=stack and 3=data, and `ovr_bad`=0.
- R8: `ovr_bad` is 1 exactly when `ovr_en`=1 and the kind is 0, 1 or 4. In that case `ovr_seg` has no effect, and the address and `seg_used` are those of the kind's default segment.
- R9: `out_valid` is `in_valid` delayed by one clock. `phys_addr`, `seg_used` and `ovr_bad` change only in the cycle after an accepted strobe and otherwise hold.
- R10: Reference kinds 5, 6 and 7 are treated exactly like kind 2, general data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: a reference is presented this cycle |
| ref_kind | input | 3 | Kind of memory reference (codes in R4 to R7, R10) |
| ovr_en | input | 1 | Segment override requested |
| ovr_seg | input | 2 | Segment named by the override |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| offset | input | 16 | Offset within the segment |
| out_valid | output | 1 | Registered result is new this cycle |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment actually used |
| ovr_bad | output | 1 | Override was refused |

## Verification
Two functions meet in the same cycle: the segment choice (default or override) and the wrapping add. A refused override must also leave the address path untouched. The bench provokes these together by sweeping all eight kind codes against both override states and all four override targets. Each point uses distinct segment values, so a wrong choice shows up as a wrong address. Some points use segment and offset values large enough to carry past bit 19. Each result is judged against an arithmetic model of the requirements on all three result outputs at once.

// File: rtl/seg_addr_pkg.sv
// Package: shared codes for the segmented address generator.
// Assumes: reference kinds are 3-bit codes and segment identities are 2-bit codes.
package seg_addr_pkg;

    typedef enum logic [2:0] {
        KIND_FETCH = 3'd0,
        KIND_STACK = 3'd1,
        KIND_DATA  = 3'd2,
        KIND_SRC   = 3'd3,
        KIND_DST   = 3'd4
    } ref_kind_e;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_e;

    localparam int unsigned NUM_SEG = 4;
    localparam int unsigned SEG_ID_W = 2;
    localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/seg_policy.sv
// Module: seg_policy
// Decides which segment a reference uses and whether an override is refused.
// Assumes: codes above KIND_DST are treated as general data. A refused
// override falls back to the kind's default segment.
module seg_policy
    import seg_addr_pkg::*;
(
    input  logic [KIND_W-1:0]   kind,
    input  logic                ovr_en,
    input  logic [SEG_ID_W-1:0] ovr_seg,
    output logic [SEG_ID_W-1:0] seg_id,
    output logic                refused
);
    seg_id_e dflt_seg;
    logic    may_override;

    // Purpose: default segment and override permission for each kind.
    always_comb begin
        case (kind)
            KIND_FETCH: begin dflt_seg = SEG_CODE;  may_override = 1'b0; end
            KIND_STACK: begin dflt_seg = SEG_STACK; may_override = 1'b0; end
            KIND_DST:   begin dflt_seg = SEG_EXTRA; may_override = 1'b0; end
            default:    begin dflt_seg = SEG_DATA;  may_override = 1'b1; end
        endcase
    end

    // Purpose: apply a permitted override, or flag a refused one.
    always_comb begin
        refused = ovr_en && !may_override;
        if (ovr_en && may_override) begin
            seg_id = ovr_seg;
        end else begin
            seg_id = dflt_seg;
        end
    end

endmodule

// File: rtl/seg_value_mux.sv
// Module: seg_value_mux
// Picks one segment value from a bank by identity, using an AND-OR tree.
// Assumes: the bank is indexed by the segment identity code.
module seg_value_mux #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned N     = 4,
    localparam int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [SEG_W-1:0] bank [N],
    input  logic [ID_W-1:0]  sel,
    output logic [SEG_W-1:0] value
);
    logic [SEG_W-1:0] masked [N];

    // Purpose: gate each entry by a decode of the select.
    for (genvar g = 0; g < N; g++) begin : g_gate
        assign masked[g] = (sel == ID_W'(g)) ? bank[g] : '0;
    end

    // Purpose: merge the gated entries.
    always_comb begin
        value = '0;
        for (int i = 0; i < N; i++) begin
            value = value | masked[i];
        end
    end

endmodule

// File: rtl/seg_addr_adder.sv
// Module: seg_addr_adder
// Shifts a segment left by SHIFT bits and adds the zero-extended offset.
// Assumes: the result is kept modulo 2^(SEG_W+SHIFT), so the carry is dropped.
module seg_addr_adder #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] off_ext;

    // Purpose: align the segment base and widen the offset.
    assign base    = {seg, {SHIFT{1'b0}}};
    assign off_ext = PA_W'(off);

    // Purpose: wrapping add at the physical address width.
    assign addr = base + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Forms a physical address from the segment a reference kind selects, plus an
// offset. The result is registered one stage after the in_valid strobe.
// Assumes: synchronous active-low reset. The result registers hold between strobes.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned SHIFT = 4,
    localparam int unsigned PA_W = SEG_W + SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [KIND_W-1:0]   ref_kind,
    input  logic                ovr_en,
    input  logic [SEG_ID_W-1:0] ovr_seg,
    input  logic [SEG_W-1:0]    seg_es,
    input  logic [SEG_W-1:0]    seg_cs,
    input  logic [SEG_W-1:0]    seg_ss,
    input  logic [SEG_W-1:0]    seg_ds,
    input  logic [OFF_W-1:0]    offset,
    output logic                out_valid,
    output logic [PA_W-1:0]     phys_addr,
    output logic [SEG_ID_W-1:0] seg_used,
    output logic                ovr_bad
);
    logic [SEG_W-1:0]    bank [NUM_SEG];
    logic [SEG_ID_W-1:0] pick_id;
    logic                pick_bad;
    logic [SEG_W-1:0]    pick_val;
    logic [PA_W-1:0]     sum;

    // Purpose: order the segment values by identity code.
    assign bank[SEG_EXTRA] = seg_es;
    assign bank[SEG_CODE]  = seg_cs;
    assign bank[SEG_STACK] = seg_ss;
    assign bank[SEG_DATA]  = seg_ds;

    seg_policy u_policy (
        .kind    (ref_kind),
        .ovr_en  (ovr_en),
        .ovr_seg (ovr_seg),
        .seg_id  (pick_id),
        .refused (pick_bad)
    );

    seg_value_mux #(.SEG_W(SEG_W), .N(NUM_SEG)) u_mux (
        .bank  (bank),
        .sel   (pick_id),
        .value (pick_val)
    );

    seg_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg  (pick_val),
        .off  (offset),
        .addr (sum)
    );

    // Purpose: strobe delay to mark a new result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Purpose: capture the result on an accepted strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
            seg_used  <= '0;
            ovr_bad   <= 1'b0;
        end else if (in_valid) begin
            phys_addr <= sum;
            seg_used  <= pick_id;
            ovr_bad   <= pick_bad;
        end
    end

endmodule

// File: rtl/seg_addr_gen_chk.sv
// Module: seg_addr_gen_chk
// Checker for seg_addr_gen: timing of the strobe, segment policy and address sum.
// Assumes: default parameters (16-bit segment and offset, 20-bit address).
module seg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  ref_kind,
    input logic        ovr_en,
    input logic [15:0] seg_es,
    input logic [15:0] seg_cs,
    input logic [15:0] seg_ss,
    input logic [15:0] seg_ds,
    input logic [15:0] offset,
    input logic        out_valid,
    input logic [19:0] phys_addr,
    input logic [1:0]  seg_used,
    input logic        ovr_bad
);
    logic [15:0] cap_seg [4];
    logic [15:0] cap_off;
    logic [15:0] used_val;
    logic [20:0] model_sum;

    // Purpose: remember the inputs of the last accepted strobe.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            cap_seg[0] <= seg_es;
            cap_seg[1] <= seg_cs;
            cap_seg[2] <= seg_ss;
            cap_seg[3] <= seg_ds;
            cap_off    <= offset;
        end
    end

    // Purpose: address implied by the reported segment.
    assign used_val  = cap_seg[seg_used];
    assign model_sum = {1'b0, used_val, 4'b0000} + {5'b0, cap_off};

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(phys_addr) && $stable(seg_used) && $stable(ovr_bad))); // R9
    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ref_kind == 3'd0) |=> seg_used == 2'd1); // R4
    AST_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ref_kind == 3'd1) |=> seg_used == 2'd2); // R5
    AST_DEST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ref_kind == 3'd4) |=> seg_used == 2'd0); // R6
    AST_DATA_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ovr_en && (ref_kind == 3'd2 || ref_kind == 3'd3)) |=> seg_used == 2'd3); // R7
    AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ovr_bad == $past(ovr_en && (ref_kind == 3'd0 || ref_kind == 3'd1 || ref_kind == 3'd4))); // R8
    AST_ADDR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> phys_addr == model_sum[19:0]); // R2

endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ref_kind  (ref_kind),
    .ovr_en    (ovr_en),
    .seg_es    (seg_es),
    .seg_cs    (seg_cs),
    .seg_ss    (seg_ss),
    .seg_ds    (seg_ds),
    .offset    (offset),
    .out_valid (out_valid),
    .phys_addr (phys_addr),
    .seg_used  (seg_used),
    .ovr_bad   (ovr_bad)
);

// File: tb/tb_seg_addr_gen.sv
// Bench for seg_addr_gen: a sweep over kind, override state and override
// target, with an arithmetic model of the requirements.
module tb_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  ref_kind;
    logic        ovr_en;
    logic [1:0]  ovr_seg;
    logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
    logic [15:0] offset;
    logic        out_valid;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;
    logic        ovr_bad;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ref_kind(ref_kind),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg), .seg_es(seg_es), .seg_cs(seg_cs),
        .seg_ss(seg_ss), .seg_ds(seg_ds), .offset(offset), .out_valid(out_valid),
        .phys_addr(phys_addr), .seg_used(seg_used), .ovr_bad(ovr_bad)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model: segment value for an identity (0 extra, 1 code, 2 stack, 3 data).
    function automatic logic [15:0] seg_of(input logic [1:0] id);
        case (id)
            2'd0: return seg_es;
            2'd1: return seg_cs;
            2'd2: return seg_ss;
            default: return seg_ds;
        endcase
    endfunction

    // Present one reference, then check the registered result one edge later.
    task automatic issue(input string tag, input logic [2:0] k, input logic en,
                         input logic [1:0] sel, input logic [15:0] off);
        logic [1:0]  e_id;
        logic        e_bad;
        logic [20:0] e_sum;
        ref_kind = k; ovr_en = en; ovr_seg = sel; offset = off; in_valid = 1'b1;
        case (k)
            3'd0: e_id = 2'd1;
            3'd1: e_id = 2'd2;
            3'd4: e_id = 2'd0;
            default: e_id = en ? sel : 2'd3;
        endcase
        e_bad = en && (k == 3'd0 || k == 3'd1 || k == 3'd4);
        e_sum = {1'b0, seg_of(e_id), 4'b0} + {5'b0, off};
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "out_valid", {31'b0, out_valid}, 32'd1);
        check(tag, "phys_addr", {12'b0, phys_addr}, {12'b0, e_sum[19:0]});
        check(tag, "seg_used", {30'b0, seg_used}, {30'b0, e_id});
        check(tag, "ovr_bad", {31'b0, ovr_bad}, {31'b0, e_bad});
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [19:0] held_a;
        logic [1:0]  held_s;
        logic        held_b;
        rst_n = 1'b0; in_valid = 1'b1; ref_kind = 3'd1; ovr_en = 1'b1; ovr_seg = 2'd2;
        seg_es = 16'h1111; seg_cs = 16'h2222; seg_ss = 16'h3333; seg_ds = 16'h4444;
        offset = 16'h5555;
        @(negedge clk); @(negedge clk);
        // R1: reset state, even with a strobe present during reset
        check("R1", "out_valid", {31'b0, out_valid}, 32'd0);
        check("R1", "phys_addr", {12'b0, phys_addr}, 32'd0);
        check("R1", "seg_used", {30'b0, seg_used}, 32'd0);
        check("R1", "ovr_bad", {31'b0, ovr_bad}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2: worked examples through the data segment
        seg_ds = 16'h1234; issue("R2", 3'd2, 1'b0, 2'd0, 16'h0022);
        check("R2", "example1", {12'b0, phys_addr}, 32'h12362);
        seg_ds = 16'h2500; issue("R2", 3'd3, 1'b0, 2'd0, 16'h95F3);
        check("R2", "example2", {12'b0, phys_addr}, 32'h2E5F3);
        // R3: wrap past FFFFFh
        seg_ds = 16'hFFFF; issue("R3", 3'd2, 1'b0, 2'd0, 16'h0010);
        check("R3", "wrap_zero", {12'b0, phys_addr}, 32'h00000);
        issue("R3", 3'd2, 1'b0, 2'd0, 16'hFFFF);
        check("R3", "wrap_max", {12'b0, phys_addr}, 32'h0FFEF);

        // Sweep R4 R5 R6 R7 R8 R10: all kinds, override states and targets
        for (int k = 0; k < 8; k++) begin
            for (int e = 0; e < 2; e++) begin
                for (int s = 0; s < 4; s++) begin
                    string tag;
                    seg_es = 16'h0100 + 16'(k * 16'h1357);
                    seg_cs = 16'h2000 + 16'(s * 16'h0F0F) + 16'(e);
                    seg_ss = 16'h7A00 + 16'(k * 16'h0321);
                    seg_ds = 16'hF000 + 16'(s * 16'h0111);
                    case (k)
                        0: tag = "R4";
                        1: tag = "R5";
                        4: tag = "R6";
                        2, 3: tag = "R7";
                        default: tag = "R10";
                    endcase
                    if (e == 1 && (k == 0 || k == 1 || k == 4)) tag = "R8";
                    issue(tag, 3'(k), 1'(e), 2'(s), 16'hF00F - 16'(k * 16'h0101));
                end
            end
        end

        // R9: idle cycles with changing inputs leave the result unchanged
        held_a = phys_addr; held_s = seg_used; held_b = ovr_bad;
        ref_kind = 3'd0; ovr_en = 1'b1; seg_cs = 16'hABCD; offset = 16'h1234;
        @(negedge clk);
        check("R9", "idle out_valid", {31'b0, out_valid}, 32'd0);
        check("R9", "idle phys_addr", {12'b0, phys_addr}, {12'b0, held_a});
        check("R9", "idle seg_used", {30'b0, seg_used}, {30'b0, held_s});
        check("R9", "idle ovr_bad", {31'b0, ovr_bad}, {31'b0, held_b});
        // R9: back-to-back strobes each produce their own result
        in_valid = 1'b1; ref_kind = 3'd1; ovr_en = 1'b0; seg_ss = 16'h0001; offset = 16'h0002;
        @(negedge clk);
        check("R9", "b2b first", {12'b0, phys_addr}, 32'h00012);
        ref_kind = 3'd4; seg_es = 16'h0003; offset = 16'h0004;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "b2b second", {12'b0, phys_addr}, 32'h00034);
        check("R9", "b2b valid", {31'b0, out_valid}, 32'd1);
        // R1: reset after activity clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "re-reset phys_addr", {12'b0, phys_addr}, 32'd0);
        check("R1", "re-reset seg_used", {30'b0, seg_used}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule